// File: doc/BRIEF.md
# Halt and Single-Step Bus Gate

This block sits between the core's external-bus request and the pins of the external bus cycle. It runs one operand transfer as one or more bus parts: a byte port takes one byte per part and a word port takes up to two. For each part it drives the address strobe and data strobe, enables the data-bus drivers on writes, and holds address, function code, size and direction steady. An external agent can pull the halt input low to freeze external bus activity at a cycle boundary. Each short release of halt lets one further step run, so the bus can be walked one cycle at a time.

Halt is sampled when the acknowledge for a part is accepted. The gate then stops only after the acknowledge has been released, and only at a word boundary of the operand, so a word moved through a byte port is never split by a stop. While stopped, both strobes are inactive and the data drivers are off. The address and control lines keep the values of the last part that ran. A bus error during a strobe ends the transfer and raises a bus-error exception request, whether or not halt is low. A core request that needs no external cycle is acknowledged at once, whatever state the gate is in.

Top module: `halt_step_gate`

## Requirements
- R1: After reset, as_n_o and ds_n_o are 1, and data_oe_o, ack_o and berr_exc_o are 0.
- R2: An operand of B bytes (siz_i 2'b01=1, 2'b10=2, 2'b11=3, 2'b00=4) runs as B parts on a byte port (port8_i=1) and as ceil(B/2) parts on a word port. Part k drives addr_o = base + k*P, where P is 1 for a byte port and 2 for a word port. siz_o gives the bytes still to move, modulo 4.
- R3: Each part asserts as_n_o low once. ds_n_o is low only while as_n_o is low. ack_o pulses once per completed operand, after dsack_ni has gone high for the final part.
- R4: halt_ni is sampled when dsack_ni is accepted. If it is low, no new part starts after dsack_ni goes high, provided an even number of the operand's bytes has moved. Otherwise the next part still runs: a 4-byte operand on a byte port stops after part 2, and a 2-byte operand on a byte port never stops between its parts.
- R5: While stopped between parts, as_n_o and ds_n_o are 1 and data_oe_o is 0. addr_o, fc_o, siz_o and rw_o keep the values of the last part that ran.
- R6: While idle with halt_ni low, a pending external request starts no bus part.
- R7: A release of halt_ni for one clock, followed by reassertion, lets exactly one further word step run (one part on a word port), after which the gate stops again or completes.
- R8: A request with ext_i=0 is acknowledged in the same cycle on ack_o and causes no bus part, even while halted.
- R9: berr_ni low during a strobe ends the part, drops the operand's remaining parts, gives no ack_o, and pulses berr_exc_o once after berr_ni and dsack_ni are both high. This applies with halt_ni low as well.
- R10: data_oe_o is 1 only for writes (rw_o=0) and only while a part is active. It is never 1 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core transfer request, held until ack_o or berr_exc_o |
| ext_i | input | 1 | Request needs the external bus |
| addr_i | input | AW | Operand start address |
| fc_i | input | FCW | Function code |
| siz_i | input | 2 | Operand size (01 byte, 10 word, 11 three bytes, 00 long) |
| rw_i | input | 1 | Direction, 1 = read |
| port8_i | input | 1 | Target port is 8 bits wide |
| halt_ni | input | 1 | Halt request, active low |
| berr_ni | input | 1 | Bus error, active low |
| dsack_ni | input | 1 | Data/size acknowledge, active low |
| ack_o | output | 1 | Request complete |
| berr_exc_o | output | 1 | Bus-error exception request pulse |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| data_oe_o | output | 1 | Data-bus output enable |
| addr_o | output | AW | Bus address |
| fc_o | output | FCW | Bus function code |
| siz_o | output | 2 | Bytes remaining, modulo 4 |
| rw_o | output | 1 | Bus direction |

## Verification
The assertions check the following on every cycle: an idle gate with halt low never leaves idle, the stopped state keeps both strobes inactive and the drivers off, and the address and control lines stay frozen while stopped. They also check that a bus error during a strobe moves the gate straight into the abort state, that internal requests pass through, and that reads never enable the data drivers. Only the bench scenarios can show the following: the number of parts and the address sequence for each operand and port width, the exact point where a halt takes effect within a dynamically sized transfer, that a single halt pulse buys exactly one word step, and that a bus error drops the remaining parts and raises one exception pulse.

// File: rtl/hsg_pkg.sv
`timescale 1ns/1ps
package hsg_pkg;
  typedef enum logic [2:0] {
    S0_IDLE  = 3'd0,
    S1_ADDR  = 3'd1,
    S2_STRB  = 3'd2,
    S3_REL   = 3'd3,
    S4_ABORT = 3'd4,
    S5_STOP  = 3'd5
  } bus_st_e;

  localparam int CNT_W = 3;

  function automatic logic [CNT_W-1:0] op_bytes(input logic [1:0] siz);
    return (siz == 2'b00) ? CNT_W'(4) : {1'b0, siz};
  endfunction
endpackage

// File: rtl/hsg_xfer_track.sv
`timescale 1ns/1ps
module hsg_xfer_track
  import hsg_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    siz_i,
  input  logic          port8_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    siz_o,
  output logic          done_o,
  output logic          word_edge_o
);
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] bytes_q, off_q, rem, step, nxt_off;
  logic             port8_q;

  always_comb begin
    rem     = bytes_q - off_q;
    step    = (port8_q || rem == CNT_W'(1)) ? CNT_W'(1) : CNT_W'(2);
    nxt_off = off_q + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      bytes_q <= '0;
      off_q   <= '0;
      port8_q <= 1'b0;
    end else if (start_i) begin
      base_q  <= addr_i;
      bytes_q <= op_bytes(siz_i);
      off_q   <= '0;
      port8_q <= port8_i;
    end else if (adv_i) begin
      off_q <= nxt_off;
    end
  end

  // address and size only move at part starts, so a stop freezes them
  assign addr_o      = base_q + AW'(off_q);
  assign siz_o       = rem[1:0];
  assign done_o      = (nxt_off == bytes_q);
  assign word_edge_o = ~nxt_off[0];

  AST_OFF_IN_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= bytes_q); // R2
endmodule

// File: rtl/hsg_ctl_hold.sv
`timescale 1ns/1ps
module hsg_ctl_hold #(
  parameter int FCW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [FCW-1:0] fc_i,
  input  logic           rw_i,
  output logic [FCW-1:0] fc_o,
  output logic           rw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_o <= '0;
      rw_o <= 1'b1;
    end else if (start_i) begin
      fc_o <= fc_i;
      rw_o <= rw_i;
    end
  end
endmodule

// File: rtl/hsg_stop_flag.sv
`timescale 1ns/1ps
module hsg_stop_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic halt_ni,
  output logic stop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stop_o <= 1'b0;
    else if (sample_i) stop_o <= ~halt_ni;
  end
endmodule

// File: rtl/halt_step_gate.sv
`timescale 1ns/1ps
module halt_step_gate
  import hsg_pkg::*;
#(
  parameter int AW  = 24,
  parameter int FCW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           ext_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [FCW-1:0] fc_i,
  input  logic [1:0]     siz_i,
  input  logic           rw_i,
  input  logic           port8_i,
  input  logic           halt_ni,
  input  logic           berr_ni,
  input  logic           dsack_ni,
  output logic           ack_o,
  output logic           berr_exc_o,
  output logic           as_n_o,
  output logic           ds_n_o,
  output logic           data_oe_o,
  output logic [AW-1:0]  addr_o,
  output logic [FCW-1:0] fc_o,
  output logic [1:0]     siz_o,
  output logic           rw_o
);
  bus_st_e st_q, st_d;
  logic    start, adv, done, word_edge, stop_q, take_ack;

  assign take_ack = (st_q == S2_STRB) && berr_ni && !dsack_ni;

  hsg_xfer_track #(.AW(AW)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .adv_i(adv),
    .addr_i(addr_i), .siz_i(siz_i), .port8_i(port8_i),
    .addr_o(addr_o), .siz_o(siz_o), .done_o(done), .word_edge_o(word_edge)
  );

  hsg_ctl_hold #(.FCW(FCW)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .fc_i(fc_i), .rw_i(rw_i), .fc_o(fc_o), .rw_o(rw_o)
  );

  hsg_stop_flag u_stop (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(take_ack),
    .halt_ni(halt_ni), .stop_o(stop_q)
  );

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    adv   = 1'b0;
    unique case (st_q)
      S0_IDLE: if (req_i && ext_i && halt_ni) begin
        st_d  = S1_ADDR;
        start = 1'b1;
      end
      S1_ADDR: st_d = S2_STRB;
      S2_STRB: begin
        if (!berr_ni)       st_d = S4_ABORT;
        else if (!dsack_ni) st_d = S3_REL;
      end
      S3_REL: if (dsack_ni) begin
        if (done) st_d = S0_IDLE;
        else if (stop_q && word_edge) st_d = S5_STOP;
        else begin
          st_d = S1_ADDR;
          adv  = 1'b1;
        end
      end
      S4_ABORT: if (berr_ni && dsack_ni) st_d = S0_IDLE;
      S5_STOP: if (halt_ni) begin
        st_d = S1_ADDR;
        adv  = 1'b1;
      end
      default: st_d = S0_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S0_IDLE;
    else         st_q <= st_d;
  end

  assign as_n_o     = !(st_q == S1_ADDR || st_q == S2_STRB);
  assign ds_n_o     = !(st_q == S2_STRB);
  // drivers drop in the same clock the stop state is entered
  assign data_oe_o  = !rw_o && (st_q == S1_ADDR || st_q == S2_STRB || st_q == S3_REL);
  assign ack_o      = (req_i && !ext_i) || (st_q == S3_REL && dsack_ni && done);
  assign berr_exc_o = (st_q == S4_ABORT) && berr_ni && dsack_ni;

  AST_IDLE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S0_IDLE && !halt_ni) |=> (st_q == S0_IDLE)); // R6
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S5_STOP) |-> (as_n_o && ds_n_o && !data_oe_o)); // R5
  AST_STOP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S5_STOP && $past(st_q) == S5_STOP) |->
      ($stable(addr_o) && $stable(fc_o) && $stable(siz_o) && $stable(rw_o))); // R5
  AST_STOP_ON_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S5_STOP && $past(st_q) == S3_REL) |-> $past(word_edge && stop_q)); // R4
  AST_BERR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S2_STRB && !berr_ni) |=> (st_q == S4_ABORT && as_n_o && !ack_o)); // R9
  AST_INT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ext_i) |-> ack_o); // R8
  AST_DS_IN_AS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_n_o |-> !as_n_o); // R3
  AST_READ_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_o |-> !data_oe_o); // R10
endmodule

// File: tb/sim_halt_step_gate.sv
`timescale 1ns/1ps
module sim_halt_step_gate;
  localparam int AW = 24;
  localparam int FCW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 0, ext_i = 1, rw_i = 1, port8_i = 0;
  logic halt_ni = 1, berr_ni = 1, dsack_ni = 1;
  logic [AW-1:0] addr_i = '0;
  logic [FCW-1:0] fc_i = '0;
  logic [1:0] siz_i = 2'b00;
  logic ack_o, berr_exc_o, as_n_o, ds_n_o, data_oe_o, rw_o;
  logic [AW-1:0] addr_o;
  logic [FCW-1:0] fc_o;
  logic [1:0] siz_o;

  always #2.5 clk = ~clk;

  halt_step_gate #(.AW(AW), .FCW(FCW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .ext_i(ext_i), .addr_i(addr_i),
    .fc_i(fc_i), .siz_i(siz_i), .rw_i(rw_i), .port8_i(port8_i), .halt_ni(halt_ni),
    .berr_ni(berr_ni), .dsack_ni(dsack_ni), .ack_o(ack_o), .berr_exc_o(berr_exc_o),
    .as_n_o(as_n_o), .ds_n_o(ds_n_o), .data_oe_o(data_oe_o), .addr_o(addr_o),
    .fc_o(fc_o), .siz_o(siz_o), .rw_o(rw_o)
  );

  int pass_n = 0, fail_n = 0, cyc = 0;
  int parts = 0, acks = 0, berrs = 0, oe_seen = 0;
  int wait_cyc = 0, wcnt = 0, berr_part = 0;
  logic prev_as = 1'b1;
  logic [AW-1:0] p_addr [4];
  logic [1:0] p_siz [4];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int n_bytes(input logic [1:0] s);
    return (s == 2'b00) ? 4 : int'(s);
  endfunction
  function automatic int exp_parts(input logic [1:0] s, input logic p8);
    return p8 ? n_bytes(s) : (n_bytes(s) + 1) / 2;
  endfunction

  // external slave: acknowledge or fault data strobes, release when strobes drop
  initial forever begin
    @(negedge clk);
    if (!ds_n_o) begin
      if (wcnt >= wait_cyc) begin
        if (berr_part != 0 && parts == berr_part) berr_ni = 1'b0;
        else dsack_ni = 1'b0;
      end else wcnt++;
    end else begin
      dsack_ni = 1'b1;
      berr_ni  = 1'b1;
      wcnt     = 0;
    end
  end

  // monitor, request retirement and watchdog
  initial forever begin
    @(negedge clk);
    #1;
    cyc++;
    if (prev_as && !as_n_o) begin
      if (parts < 4) begin
        p_addr[parts] = addr_o;
        p_siz[parts]  = siz_o;
      end
      parts++;
    end
    prev_as = as_n_o;
    if (data_oe_o) oe_seen++;
    if (ack_o) acks++;
    if (berr_exc_o) berrs++;
    if (ack_o || berr_exc_o) req_i = 1'b0;
    if (cyc > 100000) begin
      fail_n++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
    end
  end

  task automatic step_n(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [1:0] s, input logic r, input logic p8);
    step_n(1);
    addr_i = a; siz_i = s; rw_i = r; port8_i = p8; ext_i = 1'b1;
    fc_i = FCW'(a[2:0]);
    parts = 0; oe_seen = 0;
    req_i = 1'b1;
  endtask

  task automatic wait_retire;
    for (int i = 0; i < 300 && req_i; i++) step_n(1);
  endtask

  int a0, b0;
  logic [AW-1:0] held_a;
  logic [1:0] held_s;

  initial begin
    void'($urandom(32'h5eed_1234));
    step_n(3);
    rst_ni = 1'b1;
    step_n(1);
    // R1 reset state
    chk(as_n_o && ds_n_o, "R1 strobes idle", {as_n_o, ds_n_o}, 2'b11);
    chk(!data_oe_o && !ack_o && !berr_exc_o, "R1 outputs low",
        {data_oe_o, ack_o, berr_exc_o}, 0);

    // R2 R3 R10 random operands, halt released
    for (int n = 0; n < 40; n++) begin
      logic [AW-1:0] a;
      logic [1:0] s;
      logic r, p8;
      bit ok;
      int np;
      a = AW'($urandom);
      s = 2'($urandom);
      r = 1'($urandom);
      p8 = 1'($urandom);
      wait_cyc = $urandom % 4;
      a0 = acks;
      issue(a, s, r, p8);
      wait_retire();
      np = exp_parts(s, p8);
      chk(parts == np, "R2 part count", parts, np);
      ok = 1;
      for (int k = 0; k < np; k++) begin
        int rem;
        rem = n_bytes(s) - k * (p8 ? 1 : 2);
        if (p_addr[k] !== a + AW'(k * (p8 ? 1 : 2))) ok = 0;
        if (p_siz[k] !== 2'(rem)) ok = 0;
      end
      chk(ok, "R2 address and size sequence", p_addr[0], a);
      chk(acks == a0 + 1, "R3 one ack per operand", acks - a0, 1);
      chk(r ? (oe_seen == 0) : (oe_seen > 0), "R10 drivers follow direction", oe_seen, r ? 0 : 1);
    end
    wait_cyc = 0;

    // R4 R5 long operand on byte port, halt after first part starts
    a0 = acks;
    issue(24'h001000, 2'b00, 1'b0, 1'b1);
    step_n(1);
    halt_ni = 1'b0;
    step_n(20);
    chk(parts == 2, "R4 long on byte port stops at word", parts, 2);
    chk(as_n_o && ds_n_o && !data_oe_o, "R5 stopped bus quiet",
        {as_n_o, ds_n_o, data_oe_o}, 3'b110);
    held_a = addr_o; held_s = siz_o;
    chk(held_a == 24'h001001 && held_s == 2'b11, "R5 last part lines held", held_a, 24'h001001);
    step_n(10);
    chk(addr_o == held_a && siz_o == held_s && rw_o == 1'b0 && fc_o == 3'd0,
        "R5 lines stable while stopped", addr_o, held_a);
    chk(acks == a0, "R4 no ack while stopped", acks - a0, 0);
    halt_ni = 1'b1;
    wait_retire();
    chk(parts == 4 && acks == a0 + 1, "R4 resumes and completes", parts, 4);

    // R4 word on byte port is not split by halt
    a0 = acks;
    issue(24'h002000, 2'b10, 1'b1, 1'b1);
    step_n(1);
    halt_ni = 1'b0;
    wait_retire();
    chk(parts == 2 && acks == a0 + 1, "R4 word on byte port runs whole", parts, 2);

    // R6 halted idle holds a pending request
    issue(24'h003000, 2'b00, 1'b1, 1'b0);
    step_n(20);
    chk(parts == 0 && !req_i == 0, "R6 no start while halted", parts, 0);

    // R8 internal request passes while halted
    a0 = acks;
    ext_i = 1'b0;
    step_n(2);
    chk(acks == a0 + 1 && parts == 0, "R8 internal ack without bus part", acks - a0, 1);

    // R7 single step of a long operand on word port
    a0 = acks;
    issue(24'h004000, 2'b00, 1'b1, 1'b0);
    step_n(2);
    halt_ni = 1'b1;
    step_n(1);
    halt_ni = 1'b0;
    step_n(15);
    chk(parts == 1 && as_n_o, "R7 one step then stop", parts, 1);
    chk(addr_o == 24'h004000 && acks == a0, "R7 first word only", addr_o, 24'h004000);
    halt_ni = 1'b1;
    step_n(1);
    halt_ni = 1'b0;
    step_n(15);
    chk(parts == 2 && acks == a0 + 1, "R7 second step completes", parts, 2);

    // R9 bus error while halted, single-stepped part faults
    a0 = acks; b0 = berrs;
    berr_part = 1;
    issue(24'h005000, 2'b00, 1'b0, 1'b0);
    step_n(2);
    halt_ni = 1'b1;
    step_n(1);
    halt_ni = 1'b0;
    step_n(15);
    chk(berrs == b0 + 1 && acks == a0 && parts == 1, "R9 fault under halt raises exception",
        berrs - b0, 1);
    halt_ni = 1'b1;

    // R9 bus error mid operand drops remaining parts
    a0 = acks; b0 = berrs;
    berr_part = 2;
    issue(24'h006000, 2'b00, 1'b1, 1'b1);
    wait_retire();
    step_n(10);
    chk(parts == 2, "R9 remaining parts dropped", parts, 2);
    chk(berrs == b0 + 1 && acks == a0, "R9 single exception no ack", berrs - b0, 1);
    chk(as_n_o && ds_n_o, "R9 bus idle after abort", {as_n_o, ds_n_o}, 2'b11);
    berr_part = 0;

    // R2 recovery after abort
    a0 = acks;
    issue(24'h007ffe, 2'b10, 1'b1, 1'b0);
    wait_retire();
    chk(parts == 1 && p_addr[0] == 24'h007ffe && acks == a0 + 1, "R2 normal after abort",
        parts, 1);

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule